// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's cache controller and tracks a single atomic reservation. A load-linked request records the block address it touched and marks the reservation as live. Three kinds of event can then kill the reservation: a snooped invalidation of that block, eviction of that block from the cache, and a context switch. A later store-conditional asks whether the reservation survived. The block answers with a pass/fail result and a separate permit that the cache controller must see before it puts the store onto the bus. A store-conditional that fails never receives the permit, so it creates no invalidation and no write traffic.

The reservation is held in a two-state machine with states RSV_EMPTY and RSV_HELD. Its transitions are: LOAD (any state to RSV_HELD, address captured), KILL (RSV_HELD to RSV_EMPTY on a matching clearing event) and CONSUME (any state to RSV_EMPTY on a store-conditional). Repeated failures can cause livelock. To prevent it, a second two-state machine, BO_READY / BO_HOLD, raises a retry hold after every failure. The transitions are ARM (BO_READY or BO_HOLD to BO_HOLD on a failure, reloading the counter), DRAIN (counting down in BO_HOLD) and RELEASE (BO_HOLD to BO_READY when the count expires). The hold length starts small, doubles on each failure up to a cap, and returns to its minimum after any success.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked pulse with no store-conditional in the same cycle makes the reservation live and captures its block address. A later load-linked replaces that address.
- R2: An invalidation whose block address equals the captured address kills the reservation. An invalidation of any other address has no effect.
- R3: Eviction of the captured block kills the reservation, and eviction of any other block has no effect. A context-switch pulse kills it whatever the address.
- R4: One cycle after a store-conditional pulse, sc_done is 1. sc_ok and bus_wr_ok are both 1 only if four conditions hold in the pulse cycle: the reservation was live, the address matched, no clearing event was present, and retry_hold was 0.
- R5: A failed store-conditional shows sc_done=1, sc_ok=0 and bus_wr_ok=0. bus_wr_ok is never 1 without sc_ok.
- R6: A store-conditional to an address other than the captured one fails.
- R7: Every store-conditional consumes the reservation, whether it passes or fails. A load-linked in the same cycle as a store-conditional is ignored.
- R8: After a failure, retry_hold is 1 for exactly D cycles, starting in the cycle sc_done rises. D starts at BO_MIN, doubles after each failure, and stops at BO_MIN<<BO_STEPS (2, 4, 8, 16, 16... by default).
- R9: A successful store-conditional returns D to BO_MIN.
- R10: A store-conditional issued while retry_hold is 1 fails, even with a live matching reservation, and restarts the hold with the next D.
- R11: After reset, no reservation is live, all outputs are 0 and D equals BO_MIN.
- R12: A clearing event in the same cycle as a store-conditional makes it fail. In the same cycle as a load-linked, the load-linked wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked pulse |
| ll_blk | input | BLK_W | Block address of the load-linked |
| sc_valid | input | 1 | Store-conditional pulse |
| sc_blk | input | BLK_W | Block address of the store-conditional |
| inv_valid | input | 1 | Snooped invalidation pulse |
| inv_blk | input | BLK_W | Invalidated block address |
| repl_valid | input | 1 | Cache eviction pulse |
| repl_blk | input | BLK_W | Evicted block address |
| ctx_switch | input | 1 | Context-switch pulse |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | Store-conditional passed |
| bus_wr_ok | output | 1 | Permit for the store to go onto the bus |
| retry_hold | output | 1 | Back-off window active; retries should wait |

## Verification
A reservation state that is live when it should be dead, or dead when it should be live, cannot be seen directly. It only shows up on the next store-conditional, as a wrong sc_ok and bus_wr_ok exactly one cycle after the pulse. For that reason every kill, keep and replace scenario ends with a store-conditional. A wrong back-off delay shows up as a retry_hold window of the wrong length, starting in the same cycle as sc_done. Measuring that length after each failure exposes any error in doubling, capping or resetting the delay.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } resv_state_e;

    typedef enum logic {
        BO_READY = 1'b0,
        BO_HOLD  = 1'b1
    } bo_state_e;
endpackage

// File: rtl/llsc_kill_match.sv
module llsc_kill_match #(
    parameter int BLK_W = 26
) (
    input  logic             held,
    input  logic [BLK_W-1:0] lock_blk,
    input  logic             inv_valid,
    input  logic [BLK_W-1:0] inv_blk,
    input  logic             repl_valid,
    input  logic [BLK_W-1:0] repl_blk,
    input  logic             ctx_switch,
    output logic             kill
);
    logic inv_hit;
    logic repl_hit;

    always_comb begin
        inv_hit  = inv_valid  && (inv_blk  == lock_blk);
        repl_hit = repl_valid && (repl_blk == lock_blk);
        kill     = ctx_switch || (held && (inv_hit || repl_hit));
    end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
    import llsc_pkg::*;
#(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_req,
    input  logic [BLK_W-1:0] ll_blk,
    input  logic             sc_req,
    input  logic             kill,
    output logic             held,
    output logic [BLK_W-1:0] lock_blk
);
    resv_state_e      state_q, state_n;
    logic [BLK_W-1:0] blk_q, blk_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            blk_q   <= '0;
        end else begin
            state_q <= state_n;
            blk_q   <= blk_n;
        end
    end

    always_comb begin
        state_n = state_q;
        blk_n   = blk_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (sc_req) begin
                    state_n = RSV_EMPTY;          // CONSUME
                end else if (ll_req) begin
                    state_n = RSV_HELD;           // LOAD
                    blk_n   = ll_blk;
                end
            end
            RSV_HELD: begin
                if (sc_req) begin
                    state_n = RSV_EMPTY;          // CONSUME
                end else if (ll_req) begin
                    state_n = RSV_HELD;           // LOAD (replace)
                    blk_n   = ll_blk;
                end else if (kill) begin
                    state_n = RSV_EMPTY;          // KILL
                end
            end
            default: state_n = RSV_EMPTY;
        endcase
    end

    always_comb begin
        held     = (state_q == RSV_HELD);
        lock_blk = blk_q;
    end

    assert_sc_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !held);
    assert_ll_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_req && !sc_req) |=> (held && lock_blk == $past(ll_blk)));
    assert_kill_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !ll_req && !sc_req) |=> !held);
endmodule

// File: rtl/llsc_judge.sv
module llsc_judge #(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_req,
    input  logic [BLK_W-1:0] sc_blk,
    input  logic             held,
    input  logic [BLK_W-1:0] lock_blk,
    input  logic             kill,
    input  logic             hold,
    output logic             win_now,
    output logic             fail_now,
    output logic             sc_done,
    output logic             sc_ok,
    output logic             bus_wr_ok
);
    logic eligible;

    always_comb begin
        eligible = held && (sc_blk == lock_blk) && !kill && !hold;
        win_now  = sc_req && eligible;
        fail_now = sc_req && !eligible;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done   <= 1'b0;
            sc_ok     <= 1'b0;
            bus_wr_ok <= 1'b0;
        end else begin
            sc_done   <= sc_req;
            sc_ok     <= win_now;
            bus_wr_ok <= sc_req && !fail_now;
        end
    end

    assert_no_write_unheld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !held) |=> !bus_wr_ok);
    assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && hold) |=> (sc_done && !sc_ok));
    assert_kill_fails_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && kill) |=> !bus_wr_ok);
endmodule

// File: rtl/llsc_backoff.sv
module llsc_backoff
    import llsc_pkg::*;
#(
    parameter int BO_MIN   = 2,
    parameter int BO_STEPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail,
    input  logic succ,
    output logic hold
);
    localparam int BO_MAX = BO_MIN << BO_STEPS;
    localparam int DLY_W  = $clog2(BO_MAX + 1);
    localparam logic [DLY_W-1:0] MIN_V  = DLY_W'(BO_MIN);
    localparam logic [DLY_W-1:0] MAX_V  = DLY_W'(BO_MAX);
    localparam logic [DLY_W-1:0] HALF_V = DLY_W'(BO_MAX / 2);

    bo_state_e        state_q, state_n;
    logic [DLY_W-1:0] cnt_q, cnt_n;
    logic [DLY_W-1:0] dly_q, dly_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BO_READY;
            cnt_q   <= '0;
            dly_q   <= MIN_V;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            dly_q   <= dly_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        dly_n   = dly_q;
        unique case (state_q)
            BO_READY: ;
            BO_HOLD: begin
                cnt_n = cnt_q - 1'b1;             // DRAIN
                if (cnt_q == 1) begin
                    state_n = BO_READY;           // RELEASE
                end
            end
            default: state_n = BO_READY;
        endcase
        if (fail) begin
            state_n = BO_HOLD;                    // ARM
            cnt_n   = dly_q;
            dly_n   = (dly_q >= HALF_V) ? MAX_V : (dly_q << 1);
        end else if (succ) begin
            dly_n = MIN_V;
        end
    end

    always_comb begin
        hold = (state_q == BO_HOLD);
    end

    assert_fail_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (hold && cnt_q == $past(dly_q)));
    assert_delay_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_q >= MIN_V) && (dly_q <= MAX_V));
    assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (cnt_q != 0));
    assert_success_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        succ |=> (dly_q == MIN_V));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int BLK_W    = 26,
    parameter int BO_MIN   = 2,
    parameter int BO_STEPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_valid,
    input  logic [BLK_W-1:0] ll_blk,
    input  logic             sc_valid,
    input  logic [BLK_W-1:0] sc_blk,
    input  logic             inv_valid,
    input  logic [BLK_W-1:0] inv_blk,
    input  logic             repl_valid,
    input  logic [BLK_W-1:0] repl_blk,
    input  logic             ctx_switch,
    output logic             sc_done,
    output logic             sc_ok,
    output logic             bus_wr_ok,
    output logic             retry_hold
);
    logic             held;
    logic [BLK_W-1:0] lock_blk;
    logic             kill;
    logic             win_now;
    logic             fail_now;

    llsc_kill_match #(.BLK_W(BLK_W)) u_kill (
        .held       (held),
        .lock_blk   (lock_blk),
        .inv_valid  (inv_valid),
        .inv_blk    (inv_blk),
        .repl_valid (repl_valid),
        .repl_blk   (repl_blk),
        .ctx_switch (ctx_switch),
        .kill       (kill)
    );

    llsc_resv #(.BLK_W(BLK_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ll_req   (ll_valid),
        .ll_blk   (ll_blk),
        .sc_req   (sc_valid),
        .kill     (kill),
        .held     (held),
        .lock_blk (lock_blk)
    );

    llsc_judge #(.BLK_W(BLK_W)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_req    (sc_valid),
        .sc_blk    (sc_blk),
        .held      (held),
        .lock_blk  (lock_blk),
        .kill      (kill),
        .hold      (retry_hold),
        .win_now   (win_now),
        .fail_now  (fail_now),
        .sc_done   (sc_done),
        .sc_ok     (sc_ok),
        .bus_wr_ok (bus_wr_ok)
    );

    llsc_backoff #(.BO_MIN(BO_MIN), .BO_STEPS(BO_STEPS)) u_backoff (
        .clk   (clk),
        .rst_n (rst_n),
        .fail  (fail_now),
        .succ  (win_now),
        .hold  (retry_hold)
    );

    assert_write_needs_resv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_ok |-> $past(held));
    assert_write_implies_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_ok |-> (sc_ok && sc_done));
    assert_fail_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_ok) |-> retry_hold);
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int BLK_W = 26;
    localparam logic [BLK_W-1:0] A = 26'h0001a40;
    localparam logic [BLK_W-1:0] B = 26'h0001a41;
    localparam logic [BLK_W-1:0] C = 26'h2abcdef;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ll_valid = 1'b0, sc_valid = 1'b0, inv_valid = 1'b0, repl_valid = 1'b0, ctx_switch = 1'b0;
    logic [BLK_W-1:0] ll_blk = '0, sc_blk = '0, inv_blk = '0, repl_blk = '0;
    logic sc_done, sc_ok, bus_wr_ok, retry_hold;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    llsc_monitor #(.BLK_W(BLK_W)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_blk(ll_blk),
        .sc_valid(sc_valid), .sc_blk(sc_blk),
        .inv_valid(inv_valid), .inv_blk(inv_blk),
        .repl_valid(repl_valid), .repl_blk(repl_blk),
        .ctx_switch(ctx_switch),
        .sc_done(sc_done), .sc_ok(sc_ok), .bus_wr_ok(bus_wr_ok), .retry_hold(retry_hold)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: pops one expected result per sc_done
    always @(negedge clk) begin
        if (rst_n && sc_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected sc_done", 1, 0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(sc_ok == e, {t, " sc_ok"}, int'(sc_ok), int'(e));
                check(bus_wr_ok == e, {t, " bus_wr_ok (R5)"}, int'(bus_wr_ok), int'(e));
            end
        end else if (rst_n) begin
            if (bus_wr_ok) check(1'b0, "R5 stray bus_wr_ok", 1, 0);
        end
    end

    task automatic do_ll(input logic [BLK_W-1:0] a);
        @(negedge clk); ll_valid = 1'b1; ll_blk = a;
        @(negedge clk); ll_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [BLK_W-1:0] a);
        @(negedge clk); inv_valid = 1'b1; inv_blk = a;
        @(negedge clk); inv_valid = 1'b0;
    endtask

    task automatic do_repl(input logic [BLK_W-1:0] a);
        @(negedge clk); repl_valid = 1'b1; repl_blk = a;
        @(negedge clk); repl_valid = 1'b0;
    endtask

    task automatic do_ctx();
        @(negedge clk); ctx_switch = 1'b1;
        @(negedge clk); ctx_switch = 1'b0;
    endtask

    // Counts retry_hold cycles starting at the sample where sc_done shows
    task automatic measure_hold(input int exp_len, input string tag);
        int n = 0;
        while (retry_hold) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_len, {tag, " hold length (R8)"}, n, exp_len);
    endtask

    task automatic do_sc(input logic [BLK_W-1:0] a, input bit exp, input int exp_len,
                         input string tag);
        @(negedge clk); sc_valid = 1'b1; sc_blk = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); sc_valid = 1'b0;
        measure_hold(exp_len, tag);
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sc_done && !sc_ok && !bus_wr_ok && !retry_hold, "R11 reset outputs",
              int'({sc_done, sc_ok, bus_wr_ok, retry_hold}), 0);

        do_ll(A); do_sc(A, 1'b1, 0, "R1 R4 basic pass");
        do_sc(A, 1'b0, 2, "R7 consumed after pass, R11 min delay");
        do_ll(A); do_inv(A); do_sc(A, 1'b0, 4, "R2 matching invalidation");
        do_ll(A); do_inv(B); do_repl(B); do_sc(A, 1'b1, 0, "R2 R3 non-matching ignored");
        do_ll(A); do_repl(A); do_sc(A, 1'b0, 2, "R3 eviction, R9 delay reset");
        do_ll(A); do_ctx(); do_sc(A, 1'b0, 4, "R3 context switch");
        do_ll(A); do_sc(B, 1'b0, 8, "R6 address mismatch");
        do_sc(A, 1'b0, 16, "R8 delay 16");
        do_sc(A, 1'b0, 16, "R8 cap");

        // R10: store-conditional during the hold window
        @(negedge clk); sc_valid = 1'b1; sc_blk = B;
        exp_q.push_back(1'b0); tag_q.push_back("R10 arming fail");
        @(negedge clk); sc_valid = 1'b0; ll_valid = 1'b1; ll_blk = A;
        check(retry_hold == 1'b1, "R10 hold active", int'(retry_hold), 1);
        @(negedge clk); ll_valid = 1'b0; sc_valid = 1'b1; sc_blk = A;
        exp_q.push_back(1'b0); tag_q.push_back("R10 sc during hold");
        @(negedge clk); sc_valid = 1'b0;
        measure_hold(16, "R10 restart");

        do_ll(A); do_ll(C); do_sc(A, 1'b0, 16, "R1 newer LL replaces");
        do_ll(C); do_sc(C, 1'b1, 0, "R9 pass after fails");

        // R12: kill in the SC cycle fails the SC
        do_ll(A);
        @(negedge clk); sc_valid = 1'b1; sc_blk = A; inv_valid = 1'b1; inv_blk = A;
        exp_q.push_back(1'b0); tag_q.push_back("R12 inv with sc");
        @(negedge clk); sc_valid = 1'b0; inv_valid = 1'b0;
        measure_hold(2, "R12 R9 min after success");

        // R12: kill in the LL cycle loses to the LL
        @(negedge clk); ll_valid = 1'b1; ll_blk = A; inv_valid = 1'b1; inv_blk = A;
        @(negedge clk); ll_valid = 1'b0; inv_valid = 1'b0;
        do_sc(A, 1'b1, 0, "R12 LL wins over inv");

        // R7: LL in the SC cycle is ignored
        @(negedge clk); sc_valid = 1'b1; sc_blk = A; ll_valid = 1'b1; ll_blk = A;
        exp_q.push_back(1'b0); tag_q.push_back("R7 sc with ll");
        @(negedge clk); sc_valid = 1'b0; ll_valid = 1'b0;
        measure_hold(2, "R7 sc with ll");
        do_sc(A, 1'b0, 4, "R7 ll ignored");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 every sc answered", exp_q.size(), 0);
        finish_run();
    end
endmodule